// File: doc/BRIEF.md
# Programmable Delayed Pulse Generator

A single output channel that emits a periodic pulse train. Three cycle counts set its shape: a start delay, a high time and a repetition period. Raising the enable input arms the channel. After the programmed delay the first pulse appears, and further pulses follow once per period for as long as enable stays high. Dropping enable stops the train at once.

Each period latches the width and period values afresh when it begins. A change written while the train runs therefore reshapes the next pulse and leaves the current one alone. The delay value is latched when enable rises, so it should be changed while the channel is off.

A period that is not larger than the width would otherwise hold the output high without end. In that case the period counter runs through its full range instead, giving one pulse per 2^CNT_W cycles. Alongside the pulse, an LED output is stretched to a fixed number of cycles at every pulse start so that the activity is visible to a person.

Top module: `pulse_train_gen`

## Requirements
- R1: With enable held high and period P greater than width W, consecutive rising edges of `pulse_o` are exactly P clock cycles apart.
- R2: Each pulse stays high for exactly W consecutive cycles. With W = 0 the output never goes high and the LED is never triggered.
- R3: If enable is first sampled high at clock edge E0 (after being low), the first pulse rises at edge E0 + D, where D is the delay value. With D = 0 it rises at E0 itself, so it is high in the cycle right after the enable was applied. The delay value is latched at E0, and changes to it while enabled have no effect on that run.
- R4: When enable is sampled low, `pulse_o` is low after that same edge and no further pulses occur. Holding enable for fewer than P cycles therefore yields a single pulse. A later re-enable restarts the delay count from zero.
- R5: If P is less than or equal to W (including P = 0), the period becomes 2^CNT_W cycles. Each pulse is still W cycles high, provided W < 2^CNT_W.
- R6: Width and period are sampled at the start of each period. A change written mid-period takes effect from the next pulse.
- R7: `led_o` goes high at the same edge as each pulse start with W > 0. After the most recent pulse start it stays high for exactly LED_CYC cycles, so every new pulse retriggers it. Dropping enable does not cut the LED stretch short.
- R8: The reset is synchronous and active high. While it is asserted, and afterwards until the next rising edge of enable, `pulse_o` and `led_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; its rising edge starts the delay |
| delay_cyc | input | CNT_W | Start delay in clock cycles |
| width_cyc | input | CNT_W | Pulse high time in clock cycles |
| period_cyc | input | CNT_W | Pulse repetition period in clock cycles |
| pulse_o | output | 1 | Registered pulse output |
| led_o | output | 1 | Stretched LED strobe |

## Verification
The bench goes after the off-by-one hazards around the start. It checks that a zero delay gives a pulse in the very first cycle, and that a design counting one extra register stage would land every first pulse one cycle late. It also rewrites the delay while the channel is running, re-enables after a partial delay, and rewrites width and period mid-period. A design that read these values live would lose or shift its first pulse, resume a stale count, or distort the pulse in flight.

On a narrow-counter instance, the bench sets the period at or below the width. A design without the wrap rule would either hold the output high or pulse at the short period. Finally, the bench checks the exact LED stretch after a single pulse and after a closely spaced train. A stretch that did not reload at each pulse would go dark too early.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic {
    DLY_IDLE = 1'b0,
    DLY_WAIT = 1'b1
  } dly_state_t;
endpackage

// File: rtl/pgen_delay.sv
module pgen_delay
  import pgen_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             arm,
  input  logic [CNT_W-1:0] delay_cyc,
  output logic             start
);
  dly_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat_d;
  logic             hit;

  assign hit   = (state == DLY_WAIT) && (cnt == lat_d);
  assign start = en && ((arm && (delay_cyc == '0)) || hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DLY_IDLE;
      cnt   <= '0;
      lat_d <= '0;
    end else if (!en) begin
      state <= DLY_IDLE;
      cnt   <= '0;
    end else if (arm) begin
      lat_d <= delay_cyc;
      cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
      state <= (delay_cyc == '0) ? DLY_IDLE : DLY_WAIT;
    end else if (hit) begin
      state <= DLY_IDLE;
    end else if (state == DLY_WAIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == DLY_WAIT) |-> (cnt <= lat_d && cnt != '0)); // R3
endmodule

// File: rtl/pgen_period.sv
module pgen_period #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic [CNT_W-1:0] width_cyc,
  input  logic [CNT_W-1:0] period_cyc,
  output logic             pulse_q,
  output logic             pulse_begin
);
  logic             running;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] lat_w;
  logic [CNT_W-1:0] lat_p;
  logic             long_mode;
  logic             restart;
  logic             pstart;

  assign long_mode   = (lat_p <= lat_w);
  assign restart     = running && en && (long_mode ? (pos == '0) : (pos == lat_p));
  assign pstart      = start || restart;
  assign pulse_begin = pstart && (width_cyc != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pos     <= '0;
      lat_w   <= '0;
      lat_p   <= '0;
      pulse_q <= 1'b0;
    end else if (!en) begin
      running <= 1'b0;
      pulse_q <= 1'b0;
    end else if (pstart) begin
      running <= 1'b1;
      pos     <= {{(CNT_W-1){1'b0}}, 1'b1};
      lat_w   <= width_cyc;
      lat_p   <= period_cyc;
      pulse_q <= (width_cyc != '0);
    end else if (running) begin
      pos     <= pos + 1'b1;
      pulse_q <= (pos < lat_w);
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pulse_q); // R4
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (pstart && width_cyc == '0) |=> !pulse_q); // R2
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    (running && !long_mode) |-> (pos <= lat_p)); // R1
endmodule

// File: rtl/pgen_led.sv
module pgen_led #(
  parameter int unsigned LED_CYC = 32'd4194304
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic led_q
);
  localparam int LW = $clog2(LED_CYC + 1);
  localparam logic [LW-1:0] RELOAD = LW'(LED_CYC - 1);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      led_q <= 1'b0;
    end else if (trig) begin
      cnt   <= RELOAD;
      led_q <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      led_q <= 1'b0;
    end
  end

  AST_LED_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= RELOAD); // R7
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> led_q); // R7
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int          CNT_W   = 32,
  parameter int unsigned LED_CYC = 32'd4194304
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] delay_cyc,
  input  logic [CNT_W-1:0] width_cyc,
  input  logic [CNT_W-1:0] period_cyc,
  output logic             pulse_o,
  output logic             led_o
);
  logic en_q;
  logic arm;
  logic start;
  logic pulse_begin;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  assign arm = en && !en_q;

  pgen_delay #(.CNT_W(CNT_W)) u_delay (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .arm       (arm),
    .delay_cyc (delay_cyc),
    .start     (start)
  );

  pgen_period #(.CNT_W(CNT_W)) u_period (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .start       (start),
    .width_cyc   (width_cyc),
    .period_cyc  (period_cyc),
    .pulse_q     (pulse_o),
    .pulse_begin (pulse_begin)
  );

  pgen_led #(.LED_CYC(LED_CYC)) u_led (
    .clk   (clk),
    .rst   (rst),
    .trig  (pulse_begin),
    .led_q (led_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pulse_o && !led_o)); // R8
  AST_LED_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> led_o); // R7
endmodule

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LED_CYC    = 20;
  localparam int NS         = 600;
  localparam int NV         = 6;
  // {delay, width, period}; expected: first rise = delay, high = width, spacing = period
  localparam logic [95:0] VEC [NV] = '{
    {32'd0, 32'd1,  32'd2},
    {32'd3, 32'd2,  32'd5},
    {32'd1, 32'd4,  32'd7},
    {32'd7, 32'd5,  32'd30},
    {32'd2, 32'd3,  32'd4},
    {32'd0, 32'd10, 32'd25}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [31:0] d = '0, w = '0, p = '0;
  logic pulse, led;
  logic en8 = 1'b0;
  logic [7:0] d8 = '0, w8 = '0, p8 = '0;
  logic pulse8, led8;

  bit smp_p [NS];
  bit smp_l [NS];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_train_gen #(.CNT_W(32), .LED_CYC(LED_CYC)) dut (
    .clk(clk), .rst(rst), .en(en), .delay_cyc(d), .width_cyc(w),
    .period_cyc(p), .pulse_o(pulse), .led_o(led));

  pulse_train_gen #(.CNT_W(8), .LED_CYC(4)) dut_wrap (
    .clk(clk), .rst(rst), .en(en8), .delay_cyc(d8), .width_cyc(w8),
    .period_cyc(p8), .pulse_o(pulse8), .led_o(led8));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rise_at(input int n);
    int c = 0;
    for (int i = 0; i < NS; i++)
      if (smp_p[i] && (i == 0 || !smp_p[i-1])) begin
        if (c == n) return i;
        c++;
      end
    return -1;
  endfunction

  function automatic int high_len(input int s);
    int c = 0;
    if (s < 0) return -1;
    for (int i = s; i < NS; i++) begin
      if (!smp_p[i]) break;
      c++;
    end
    return c;
  endfunction

  task automatic clear_smp();
    for (int i = 0; i < NS; i++) begin smp_p[i] = 0; smp_l[i] = 0; end
  endtask

  task automatic idle(input int n);
    @(negedge clk); en = 1'b0; en8 = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    int lit;
    // R8: outputs stay low during reset even with enable high
    d = 0; w = 5; p = 10; en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 pulse in reset", int'(pulse), 0);
      chk("R8 led in reset", int'(led), 0);
    end
    en = 1'b0; rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pulse after reset", int'(pulse), 0);
    chk("R8 led after reset", int'(led), 0);

    // vector table: R1 R2 R3 R7
    for (int v = 0; v < NV; v++) begin
      idle(3);
      clear_smp();
      d = VEC[v][95:64]; w = VEC[v][63:32]; p = VEC[v][31:0]; en = 1'b1;
      capture(NS);
      en = 1'b0;
      r0 = rise_at(0);
      chk("R3 first rise", r0, int'(VEC[v][95:64]));
      chk("R2 high time", high_len(r0), int'(VEC[v][63:32]));
      chk("R1 spacing", rise_at(1) - r0, int'(VEC[v][31:0]));
      if (r0 >= 0) chk("R7 led at pulse", int'(smp_l[r0]), 1);
    end

    // R2: zero width never pulses, LED stays dark
    idle(30); clear_smp();
    d = 0; w = 0; p = 5; en = 1'b1;
    capture(40);
    chk("R2 zero width rise", rise_at(0), -1);
    lit = 0;
    for (int i = 0; i < 40; i++) if (smp_l[i]) lit++;
    chk("R2 zero width led", lit, 0);

    // R4: disable mid-pulse cuts the train
    idle(3); clear_smp();
    d = 0; w = 10; p = 20; en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
      if (i == 3) en = 1'b0;
    end
    chk("R4 high before disable", int'(smp_p[3]), 1);
    chk("R4 low after disable", int'(smp_p[4]), 0);
    chk("R4 no later pulse", rise_at(1), -1);

    // R4: short enable gives single pulse
    idle(3); clear_smp();
    d = 0; w = 2; p = 50; en = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
      if (i == 9) en = 1'b0;
    end
    chk("R4 single pulse first", rise_at(0), 0);
    chk("R4 single pulse only", rise_at(1), -1);

    // R4: re-enable restarts delay from zero
    idle(3); clear_smp();
    d = 4; w = 1; p = 100; en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
      if (i == 2) en = 1'b0;
      if (i == 5) en = 1'b1;
    end
    chk("R4 delay restart", rise_at(0), 10);

    // R3: delay rewritten while enabled is ignored
    idle(3); clear_smp();
    d = 5; w = 2; p = 40; en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
      if (i == 1) d = 1;
    end
    chk("R3 delay latched", rise_at(0), 5);

    // R6: mid-period rewrite applies from next period
    idle(3); clear_smp();
    d = 0; w = 2; p = 10; en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
      if (i == 3) begin w = 4; p = 6; end
    end
    chk("R6 current width kept", high_len(rise_at(0)), 2);
    chk("R6 current period kept", rise_at(1), 10);
    chk("R6 new width", high_len(rise_at(1)), 4);
    chk("R6 new period", rise_at(2), 16);

    // R7: LED stretch after one pulse
    idle(30); clear_smp();
    d = 0; w = 1; p = 50; en = 1'b1;
    capture(60);
    chk("R7 led last lit cycle", int'(smp_l[LED_CYC-1]), 1);
    chk("R7 led off after stretch", int'(smp_l[LED_CYC]), 0);

    // R7: retrigger by a pulse train, disable does not cut stretch
    idle(30); clear_smp();
    d = 0; w = 1; p = 8; en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); smp_p[i] = pulse; smp_l[i] = led;
      if (i == 17) en = 1'b0;
    end
    chk("R7 retrigger lit", int'(smp_l[16+LED_CYC-1]), 1);
    chk("R7 retrigger off", int'(smp_l[16+LED_CYC]), 0);

    // R5: period not above width wraps the 8-bit counter
    idle(3); clear_smp();
    d8 = 0; w8 = 3; p8 = 2; en8 = 1'b1;
    for (int i = 0; i < 520; i++) begin
      @(negedge clk); smp_p[i] = pulse8; smp_l[i] = led8;
    end
    chk("R5 wrap spacing", rise_at(1), 256);
    chk("R5 wrap width", high_len(0), 3);

    idle(3); clear_smp();
    d8 = 0; w8 = 1; p8 = 0; en8 = 1'b1;
    for (int i = 0; i < 520; i++) begin
      @(negedge clk); smp_p[i] = pulse8; smp_l[i] = led8;
    end
    chk("R5 zero period spacing", rise_at(1), 256);
    chk("R5 zero period width", high_len(0), 1);
    en8 = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule